// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This peripheral produces a counted train of configuration clock pulses on a single output. Software, or a sequencer that acts like it, writes a pulse count into a register on a simple 32-bit word-aligned register bus. That write launches a burst of exactly that many pulses. Each pulse is high for one system clock and low for the next. When the last pulse has been sent, a sticky completion flag is raised. The controlling agent polls that flag and clears it by writing a one.

A typical sequence runs like this. The agent clears the flag, writes the count and polls the flag until it reads one, then clears it again. Common lengths are 256 pulses to flush a target's error state, and 2047 pulses ahead of data streaming. While a burst runs, the count register reads back how many pulses are still owed. A `busy` output mirrors the running state for hardware that watches it directly.

Top module: `cbg_burst_gen`

## Requirements
- R1: The count register is at byte offset 0x08 and the status register is at byte offset 0x0C. A read of any other offset returns zero.
- R2: A write of N (N > 0) to the count register while idle produces exactly N pulses on `dclk`. Each pulse is high for one cycle and then low for one cycle, and `dclk` is never high while idle.
- R3: `busy` rises on the clock edge that accepts a nonzero count and falls exactly 2N cycles later. On that same edge the done flag (status bit 0) becomes 1.
- R4: Writing a status word with bit 0 set clears the done flag. Writing a status word with bit 0 clear leaves the flag unchanged.
- R5: Writing a count of zero sets the done flag on the next edge, produces no pulses and never asserts `busy`.
- R6: A count write while `busy` is high is ignored, and the running burst continues to its end unchanged.
- R7: While a burst runs, reading the count register returns the number of pulses not yet completed. This is N right after the start, and it drops by one each time a pulse falls.
- R8: The done flag is sticky. It stays set until it is cleared, and starting a new burst does not clear it.
- R9: After reset, `dclk` and `busy` are low, the done flag is clear and the count register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dclk | output | 1 | Configuration clock pulse output |
| busy | output | 1 | High while a burst is running |

## Verification
The bench targets four corner cases:

- **One-pulse burst.** A design that tests for the last pulse off by one would emit two pulses or none.
- **Zero count.** A naive counter would wrap and run for 65,535 pulses, or would never raise the done flag.
- **Count write during a burst.** A design that reloads the counter would shorten the burst, and the remaining-count readback would jump.
- **Done flag handling.** The flag must survive a new burst start and a status write of zero. A design that treats every status write as a clear, or that clears the flag on start, would drop the flag that a poller is waiting for.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned OFS_COUNT  = 32'h08;
    localparam int unsigned OFS_STATUS = 32'h0C;
    localparam int unsigned DONE_BIT   = 0;

    typedef struct packed {
        logic start;
        logic clear;
    } cbg_cmd_t;
endpackage

// File: rtl/cbg_regif.sv
module cbg_regif
    import cbg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  remain_i,
    input  logic              done_i,
    output cbg_cmd_t          cmd_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [BUS_W-1:0]  rdata_o
);
    logic sel_count;
    logic sel_status;
    logic unused_hi_bits;

    assign sel_count  = (addr_i == ADDR_W'(OFS_COUNT));
    assign sel_status = (addr_i == ADDR_W'(OFS_STATUS));

    assign unused_hi_bits = ^wdata_i[BUS_W-1:CNT_W];

    always_comb begin
        cmd_o.start = wr_i && sel_count;
        cmd_o.clear = wr_i && sel_status && wdata_i[DONE_BIT];
        count_o     = wdata_i[CNT_W-1:0];
        rdata_o     = '0;
        if (sel_count) begin
            rdata_o = BUS_W'(remain_i);
        end else if (sel_status) begin
            rdata_o[DONE_BIT] = done_i;
        end
    end
endmodule

// File: rtl/cbg_pulse_engine.sv
module cbg_pulse_engine
    import cbg_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cbg_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             dclk_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] remain_o
);
    localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
        logic             busy;
        logic             dclk;
        logic             done;
    } eng_t;

    eng_t st_d, st_q;
    logic finish_d;

    always_comb begin
        st_d     = st_q;
        finish_d = 1'b0;
        if (st_q.busy) begin
            if (!st_q.dclk) begin
                st_d.dclk = 1'b1;
            end else begin
                st_d.dclk   = 1'b0;
                st_d.remain = st_q.remain - 1'b1;
                if (st_q.remain == LAST_PULSE) begin
                    st_d.busy = 1'b0;
                    finish_d  = 1'b1;
                end
            end
        end else if (cmd_i.start) begin
            if (count_i == '0) begin
                finish_d = 1'b1;
            end else begin
                st_d.busy   = 1'b1;
                st_d.remain = count_i;
                st_d.dclk   = 1'b0;
            end
        end
        if (cmd_i.clear) begin
            st_d.done = 1'b0;
        end
        if (finish_d) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dclk_o   = st_q.dclk;
    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign remain_o = st_q.remain;

    assert_pulse_low_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |=> !dclk_o);
    assert_no_pulse_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !dclk_o);
    assert_done_on_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    assert_clear_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.clear && !busy_o) |=> !done_o);
    assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.start && !busy_o && count_i == '0) |=> (done_o && !busy_o));
    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.start && busy_o && !dclk_o) |=> (remain_o == $past(remain_o)));
    assert_remain_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && dclk_o) |=> (remain_o == $past(remain_o) - 1'b1));
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cmd_i.clear) |=> done_o);
endmodule

// File: rtl/cbg_burst_gen.sv
module cbg_burst_gen
    import cbg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              dclk,
    output logic              busy
);
    cbg_cmd_t         cmd;
    logic [CNT_W-1:0] count_val;
    logic [CNT_W-1:0] remain;
    logic             done;

    cbg_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regif_i (
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .remain_i (remain),
        .done_i   (done),
        .cmd_o    (cmd),
        .count_o  (count_val),
        .rdata_o  (bus_rdata)
    );

    cbg_pulse_engine #(.CNT_W(CNT_W)) engine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .count_i  (count_val),
        .dclk_o   (dclk),
        .busy_o   (busy),
        .done_o   (done),
        .remain_o (remain)
    );
endmodule

// File: tb/cbg_burst_gen_tb_top.sv
module cbg_burst_gen_tb_top;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned NVEC   = 7;
    localparam logic [7:0] A_CNT  = 8'h08;
    localparam logic [7:0] A_STAT = 8'h0C;
    // stimulus count and expected busy cycles (2N)
    localparam int unsigned VEC_CNT[NVEC] = '{1, 2, 3, 7, 100, 256, 2047};
    localparam int unsigned VEC_CYC[NVEC] = '{2, 4, 6, 14, 200, 512, 4094};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dclk;
    logic        busy;

    int checks = 0;
    int fails = 0;
    int pulse_cnt = 0;
    logic finished = 1'b0;

    cbg_burst_gen #(.ADDR_W(ADDR_W), .CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dclk(dclk), .busy(busy)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (dclk) pulse_cnt <= pulse_cnt + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 10000) begin
            @(negedge clk);
            cyc++;
        end
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(dclk == 1'b0, "R9 dclk", dclk, 0);
        check(busy == 1'b0, "R9 busy", busy, 0);
        bus_read(A_CNT, rd);  check(rd == 0, "R9 count", rd, 0);
        bus_read(A_STAT, rd); check(rd == 0, "R9 status", rd, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table-driven bursts: R2 R3 R4
        for (int v = 0; v < NVEC; v++) begin
            bus_write(A_STAT, 32'h1);
            #1;
            bus_read(A_STAT, rd); check(rd == 0, "R4 clear", rd, 0);
            pulse_cnt = 0;
            bus_write(A_CNT, VEC_CNT[v]);
            check(busy == 1'b1, "R3 busy start", busy, 1);
            wait_idle(cyc);
            check(pulse_cnt == VEC_CNT[v], "R2 pulses", pulse_cnt, VEC_CNT[v]);
            check(cyc == VEC_CYC[v], "R3 busy cycles", cyc, VEC_CYC[v]);
            bus_read(A_STAT, rd); check(rd == 1, "R3 done", rd, 1);
        end

        // R4: writing 0 to done bit has no effect
        bus_write(A_STAT, 32'h0);
        #1;
        bus_read(A_STAT, rd); check(rd == 1, "R4 write zero", rd, 1);

        // R8: done stays set across a new burst start
        bus_write(A_CNT, 32'd4);
        #1;
        bus_read(A_STAT, rd); check(rd == 1, "R8 sticky", rd, 1);
        wait_idle(cyc);
        bus_write(A_STAT, 32'h1);

        // R7: remaining count readback
        bus_write(A_CNT, 32'd6);
        #1;
        bus_read(A_CNT, rd); check(rd == 6, "R7 remain start", rd, 6);
        repeat (4) @(negedge clk);
        #1;
        bus_read(A_CNT, rd); check(rd == 4, "R7 remain mid", rd, 4);
        wait_idle(cyc);
        bus_read(A_CNT, rd); check(rd == 0, "R7 remain end", rd, 0);
        bus_write(A_STAT, 32'h1);

        // R6: count write during burst ignored
        pulse_cnt = 0;
        bus_write(A_CNT, 32'd10);
        repeat (3) @(negedge clk);
        bus_write(A_CNT, 32'd3);
        #1;
        bus_read(A_CNT, rd); check(rd == 8, "R6 remain kept", rd, 8);
        wait_idle(cyc);
        check(pulse_cnt == 10, "R6 pulses", pulse_cnt, 10);
        bus_write(A_STAT, 32'h1);

        // R5: zero count
        pulse_cnt = 0;
        bus_write(A_CNT, 32'd0);
        #1;
        check(busy == 1'b0, "R5 no busy", busy, 0);
        bus_read(A_STAT, rd); check(rd == 1, "R5 done", rd, 1);
        repeat (4) @(negedge clk);
        #1;
        check(pulse_cnt == 0, "R5 no pulses", pulse_cnt, 0);

        // R1: unmapped offsets read zero
        bus_read(8'h00, rd); check(rd == 0, "R1 unmapped 0x00", rd, 0);
        bus_read(8'h04, rd); check(rd == 0, "R1 unmapped 0x04", rd, 0);
        bus_read(8'h10, rd); check(rd == 0, "R1 unmapped 0x10", rd, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule